// File: doc/BRIEF.md
# AXI4-Lite Register Request Queue

This block sits between a host that speaks AXI4-Lite and a bank of control registers. It takes requests from the host's write-address, write-data and read-address channels and stores each one as a single queue entry. The oldest entry is shown to the register bank as an enable, a read/write flag, byte enables, an address and write data. It stays on that port until the bank acknowledges it. A write is taken only when its address and data arrive in the same cycle. The register bank never does a read and a write at once, so one address field in each entry holds either kind of address.

A request whose address is outside the register window, or not aligned to a word, is never shown to the bank. When it reaches the head of the queue, the block raises a one-cycle error strobe toward a companion response queue, which then stores an error response. That response queue also reports how many free places it has. Requests leave the head only while the number of consumed requests still waiting for their response is below that free-place count.

A read and a write may arrive in the same cycle when only one slot is free. In that case the write takes the slot, and the read waits in a one-entry holding buffer until it can enter the queue.

Top module: `reg_req_queue`

## Requirements
- R1: Every queue entry carries a single address field. A read is presented with `rb_rnw`=1, `rb_be` all ones and its read address on `rb_addr`. A write is presented with `rb_rnw`=0, its write address, its strobes on `rb_be` and its data on `rb_wdata`.
- R2: With `ce` high, the three ready outputs are high by default. All three are low while the queue holds `DEPTH` entries.
- R3: A write is accepted only when `s_awvalid` and `s_wvalid` are both high. If `s_awvalid` is high alone, `s_awready` is low. If `s_wvalid` is high alone, `s_wready` is low. Nothing is queued in either case.
- R4: A read and a write may be offered together when exactly one slot is free. The write takes the slot and the read is held in the holding buffer. All three ready outputs stay low until the held read has entered the queue and a slot is free again. The read is presented after that write.
- R5: Entries reach the register-bank port in arrival order. The head entry keeps its fields stable until `rb_ack` is sampled high with `rb_en`. It is then removed and the next entry is presented.
- R6: The head is consumed, either forwarded with `rb_en` or flagged with `rsp_err`, only while the count of consumed requests not yet matched by `rsp_stored` is less than `rsp_free`.
- R7: A request is erroneous when its address is at or above `WIN_BYTES`, or when its low two address bits are not zero (4-byte words by default). At the head of the queue it raises `rsp_err` for one cycle, with `rsp_rnw` giving its kind. It never asserts `rb_en` and is removed without `rb_ack`.
- R8: A read and a write offered together when two or more slots are free are both accepted in that cycle. The write is queued ahead of the read.
- R9: While `ce` is low, all ready outputs, `rb_en` and `rsp_err` are low, and no state changes.
- R10: After reset the queue and the holding buffer are empty. `rb_en` and `rsp_err` are low and the ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ce | input | 1 | Chip enable for all state updates |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| rb_en | output | 1 | Request presented to register bank |
| rb_rnw | output | 1 | 1 = read, 0 = write |
| rb_be | output | DATA_W/8 | Byte enables |
| rb_addr | output | ADDR_W | Register address |
| rb_wdata | output | DATA_W | Write data |
| rb_ack | input | 1 | Register bank accepts the presented request |
| rsp_free | input | CRD_W | Free places in the response queue |
| rsp_stored | input | 1 | Response queue stored one response this cycle |
| rsp_err | output | 1 | Store an error response for the head request |
| rsp_rnw | output | 1 | Kind of the request being consumed |

## Verification
The assertions assume the following about the inputs:
- `rsp_stored` is pulsed once for each consumed request, and never before that request has been consumed.
- `rb_ack` is only meaningful while `rb_en` is high.
- Host inputs change only between clock edges.

The stimulus respects these assumptions:
- A model of the response queue answers each consumed request with one `rsp_stored` pulse. It answers in the next cycle, or by hand when the credit path is being tested.
- The register-bank model acknowledges only a presented request.
- All inputs are driven at the falling edge.

// File: rtl/rrq_pkg.sv
package rrq_pkg;

  typedef enum logic {
    RRQ_WRITE = 1'b0,
    RRQ_READ  = 1'b1
  } rrq_kind_e;

  // Out of window or not aligned to a register word.
  function automatic logic rrq_bad_addr(input logic [31:0] addr,
                                        input logic [31:0] win_bytes,
                                        input logic [31:0] align_mask);
    return (addr >= win_bytes) || ((addr & align_mask) != 32'd0);
  endfunction

endpackage

// File: rtl/rrq_fifo.sv
module rrq_fifo #(
  parameter int W     = 46,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce,
  input  logic          push0,
  input  logic [W-1:0]  din0,
  input  logic          push1,
  input  logic [W-1:0]  din1,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          head_v,
  output logic [CW-1:0] cnt
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, rd_d, wr_q, wr_d, wr_1;
  logic [CW-1:0] cnt_d;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wr_1  = ptr_inc(wr_q);
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt;
    if (ce) begin
      if (push0 && push1) wr_d = ptr_inc(wr_1);
      else if (push0)     wr_d = wr_1;
      if (pop)            rd_d = ptr_inc(rd_q);
      cnt_d = cnt + CW'(push0) + CW'(push1) - CW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
      cnt  <= '0;
    end else if (ce) begin
      rd_q <= rd_d;
      wr_q <= wr_d;
      cnt  <= cnt_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (ce && push0 && (wr_q == PW'(i)))      mem[i] <= din0;
      else if (ce && push1 && (wr_1 == PW'(i))) mem[i] <= din1;
    end
  end

  assign dout   = mem[rd_q];
  assign head_v = (cnt != '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && cnt == CW'(DEPTH) && !pop) |-> !push0); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && pop) |-> head_v); // R5

endmodule

// File: rtl/rrq_accept.sv
module rrq_accept
  import rrq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int WIN_BYTES = 64,
  localparam int BE_W     = DATA_W / 8,
  localparam int W        = 2 + BE_W + ADDR_W + DATA_W,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              awvalid,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   wstrb,
  input  logic              arvalid,
  input  logic [ADDR_W-1:0] araddr,
  output logic              awready,
  output logic              wready,
  output logic              arready,
  input  logic [CW-1:0]     cnt,
  output logic              push0,
  output logic [W-1:0]      din0,
  output logic              push1,
  output logic [W-1:0]      din1
);

  localparam logic [31:0] ALIGN_MASK = 32'(BE_W - 1);

  logic [W-1:0] wr_ent, rd_ent, hb_q, hb_d;
  logic         hb_v, hb_v_d;
  logic         full, blocked, two_free, wr_go, rd_go;

  assign wr_ent = {RRQ_WRITE, rrq_bad_addr(32'(awaddr), 32'(WIN_BYTES), ALIGN_MASK),
                   wstrb, awaddr, wdata};
  assign rd_ent = {RRQ_READ, rrq_bad_addr(32'(araddr), 32'(WIN_BYTES), ALIGN_MASK),
                   {BE_W{1'b1}}, araddr, {DATA_W{1'b0}}};

  assign full     = (cnt == CW'(DEPTH));
  assign two_free = (CW'(DEPTH) - cnt) >= CW'(2);
  assign blocked  = !ce || full || hb_v;

  assign awready = !blocked && !(awvalid && !wvalid);
  assign wready  = !blocked && !(wvalid && !awvalid);
  assign arready = !blocked;

  assign wr_go = awvalid && wvalid && !blocked;
  assign rd_go = arvalid && !blocked;

  always_comb begin
    push0  = 1'b0;
    push1  = 1'b0;
    din0   = wr_ent;
    din1   = rd_ent;
    hb_d   = hb_q;
    hb_v_d = hb_v;
    if (ce && hb_v && !full) begin
      push0  = 1'b1;
      din0   = hb_q;
      hb_v_d = 1'b0;
    end else if (wr_go) begin
      push0 = 1'b1;
      if (rd_go) begin
        if (two_free) begin
          push1 = 1'b1;
        end else begin
          hb_d   = rd_ent;
          hb_v_d = 1'b1;
        end
      end
    end else if (rd_go) begin
      push0 = 1'b1;
      din0  = rd_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hb_v <= 1'b0;
    else if (ce) hb_v <= hb_v_d;
  end

  always_ff @(posedge clk) begin
    if (ce) hb_q <= hb_d;
  end

  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (!awready && !wready && !arready)); // R2
  AST_AW_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (awvalid && !wvalid) |-> !awready); // R3
  AST_W_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wvalid && !awvalid) |-> !wready); // R3
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    hb_v |-> (!awready && !wready && !arready)); // R4
  AST_CE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (!push0 && !push1 && $stable(hb_v))); // R9

endmodule

// File: rtl/rrq_credit.sv
module rrq_credit #(
  parameter int CRD_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             consume,
  input  logic             stored,
  input  logic [CRD_W-1:0] free_slots,
  output logic             ok
);

  logic [CRD_W-1:0] out_q, out_d;

  assign ok = (out_q < free_slots);

  always_comb begin
    out_d = out_q;
    if (ce) out_d = out_q + CRD_W'(consume) - CRD_W'(stored);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_q <= '0;
    else if (ce) out_q <= out_d;
  end

  AST_CREDIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && consume) |-> ok); // R6
  AST_STORE_MATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && stored) |-> (out_q != '0)); // R6

endmodule

// File: rtl/reg_req_queue.sv
module reg_req_queue #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 4,
  parameter int WIN_BYTES = 64,
  parameter int CRD_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [ADDR_W-1:0]   s_awaddr,
  input  logic                s_wvalid,
  output logic                s_wready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_arvalid,
  output logic                s_arready,
  input  logic [ADDR_W-1:0]   s_araddr,
  output logic                rb_en,
  output logic                rb_rnw,
  output logic [DATA_W/8-1:0] rb_be,
  output logic [ADDR_W-1:0]   rb_addr,
  output logic [DATA_W-1:0]   rb_wdata,
  input  logic                rb_ack,
  input  logic [CRD_W-1:0]    rsp_free,
  input  logic                rsp_stored,
  output logic                rsp_err,
  output logic                rsp_rnw
);

  localparam int BE_W = DATA_W / 8;
  localparam int W    = 2 + BE_W + ADDR_W + DATA_W;
  localparam int CW   = $clog2(DEPTH + 1);

  logic          push0, push1, pop, head_v, credit_ok, head_err;
  logic [W-1:0]  din0, din1, head;
  logic [CW-1:0] cnt;

  rrq_accept #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .WIN_BYTES(WIN_BYTES)) u_accept (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .awvalid(s_awvalid), .awaddr(s_awaddr), .wvalid(s_wvalid), .wdata(s_wdata),
    .wstrb(s_wstrb), .arvalid(s_arvalid), .araddr(s_araddr),
    .awready(s_awready), .wready(s_wready), .arready(s_arready),
    .cnt(cnt), .push0(push0), .din0(din0), .push1(push1), .din1(din1)
  );

  rrq_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .push0(push0), .din0(din0), .push1(push1), .din1(din1),
    .pop(pop), .dout(head), .head_v(head_v), .cnt(cnt)
  );

  rrq_credit #(.CRD_W(CRD_W)) u_credit (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .consume(pop), .stored(rsp_stored), .free_slots(rsp_free), .ok(credit_ok)
  );

  assign rb_rnw   = head[W-1];
  assign head_err = head[W-2];
  assign rb_be    = head[W-3 -: BE_W];
  assign rb_addr  = head[DATA_W +: ADDR_W];
  assign rb_wdata = head[DATA_W-1:0];
  assign rsp_rnw  = head[W-1];

  assign rb_en   = ce && head_v && credit_ok && !head_err;
  assign rsp_err = ce && head_v && credit_ok && head_err;
  assign pop     = rsp_err || (rb_en && rb_ack);

  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_en && !rb_ack) |=> ($stable(rb_addr) && $stable(rb_wdata) && $stable(rb_rnw))); // R5
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rb_en); // R7
  AST_CE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ce |-> (!rb_en && !rsp_err && !s_arready)); // R9

endmodule

// File: tb/reg_req_queue_test.sv
module reg_req_queue_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          err;
    bit          rnw;
    logic [3:0]  be;
    logic [7:0]  addr;
    logic [31:0] data;
  } item_t;

  logic clk = 1'b0;
  logic rst_n, ce;
  logic s_awvalid, s_wvalid, s_arvalid;
  logic s_awready, s_wready, s_arready;
  logic [7:0] s_awaddr, s_araddr;
  logic [31:0] s_wdata;
  logic [3:0] s_wstrb;
  logic rb_en, rb_rnw, rb_ack;
  logic [3:0] rb_be;
  logic [7:0] rb_addr;
  logic [31:0] rb_wdata;
  logic [2:0] rsp_free;
  logic rsp_stored, rsp_err, rsp_rnw;

  int checks = 0, failures = 0;
  int consumed = 0;
  bit ack_en = 1'b0, auto_store = 1'b1, pend = 1'b0, man_store = 1'b0;
  item_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_req_queue uut (
    .clk(clk), .rst_n(rst_n), .ce(ce),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awaddr(s_awaddr),
    .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
    .s_arvalid(s_arvalid), .s_arready(s_arready), .s_araddr(s_araddr),
    .rb_en(rb_en), .rb_rnw(rb_rnw), .rb_be(rb_be), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_ack(rb_ack), .rsp_free(rsp_free), .rsp_stored(rsp_stored),
    .rsp_err(rsp_err), .rsp_rnw(rsp_rnw)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_bad(input logic [7:0] a);
    return (a >= 8'd64) || (a[1:0] != 2'b00);
  endfunction

  // Scoreboard monitor: register-bank model plus response-queue model.
  always @(negedge clk) begin
    #2;
    rsp_stored = (auto_store && pend) || man_store;
    pend = 1'b0;
    man_store = 1'b0;
    rb_ack = 1'b0;
    if (rst_n && rb_en && ack_en) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected rb_en", rb_addr, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(!e.err, "R7 erroneous request forwarded", rb_addr, e.addr);
        chk(rb_rnw == e.rnw && rb_addr == e.addr && rb_be == e.be, "R1/R5 head fields",
            {rb_rnw, rb_be, rb_addr}, {e.rnw, e.be, e.addr});
        if (!e.rnw) chk(rb_wdata == e.data, "R1 write data", rb_wdata, e.data);
      end
      rb_ack = 1'b1;
      consumed++;
      pend = 1'b1;
    end
    if (rst_n && rsp_err) begin
      if (exp_q.size() == 0) chk(0, "R7 unexpected rsp_err", 1, 0);
      else begin
        item_t e;
        e = exp_q.pop_front();
        chk(e.err && rsp_rnw == e.rnw, "R7 error strobe", {rsp_err, rsp_rnw}, {e.err, e.rnw});
      end
      consumed++;
      pend = 1'b1;
    end
  end

  // Driver: offers a write, a read or both; queues the expected items on acceptance.
  task automatic host(input bit dw, input bit dr, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [3:0] ws, input logic [7:0] ra);
    item_t e;
    @(negedge clk);
    s_awvalid = dw; s_wvalid = dw; s_awaddr = wa; s_wdata = wd; s_wstrb = ws;
    s_arvalid = dr; s_araddr = ra;
    forever begin
      #1;
      if ((!dw || (s_awready && s_wready)) && (!dr || s_arready)) break;
      @(negedge clk);
    end
    if (dw) begin
      e = '{is_bad(wa), 1'b0, ws, wa, wd};
      exp_q.push_back(e);
    end
    if (dr) begin
      e = '{is_bad(ra), 1'b1, 4'hF, ra, 32'h0};
      exp_q.push_back(e);
    end
    @(posedge clk);
    #1;
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int c0;
    rst_n = 1'b0; ce = 1'b1; rb_ack = 1'b0; rsp_stored = 1'b0; rsp_free = 3'd4;
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
    s_awaddr = '0; s_araddr = '0; s_wdata = '0; s_wstrb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk(!rb_en && !rsp_err, "R10 outputs idle", {rb_en, rsp_err}, 0);
    chk(s_awready && s_wready && s_arready, "R10/R2 readies high", {s_awready, s_wready, s_arready}, 3'b111);

    // R3 lone address or data
    @(negedge clk);
    s_awvalid = 1'b1; s_awaddr = 8'h04;
    #1;
    chk(!s_awready && s_wready, "R3 lone address", {s_awready, s_wready}, 2'b01);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b1;
    #1;
    chk(s_awready && !s_wready, "R3 lone data", {s_awready, s_wready}, 2'b10);
    @(negedge clk);
    s_wvalid = 1'b0;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0 && consumed == 0, "R3 nothing queued", consumed, 0);

    // R2 fill with acks off, R5 order after enabling acks
    ack_en = 1'b0;
    for (int i = 0; i < 4; i++) host(1, 0, 8'(4*i), 32'hA000 + 32'(i), 4'(i + 3), 8'h0);
    @(negedge clk); #1;
    chk(!s_awready && !s_wready && !s_arready, "R2 full stall", {s_awready, s_wready, s_arready}, 0);
    chk(!rb_ack, "R5 head held without ack", rb_ack, 0);
    ack_en = 1'b1;
    drain();
    chk(consumed == 4, "R5 all writes consumed", consumed, 4);

    // R1 reads
    for (int i = 0; i < 3; i++) host(0, 1, 8'h0, 32'h0, 4'h0, 8'(8 + 4*i));
    drain();
    chk(consumed == 7, "R1 reads consumed", consumed, 7);

    // R8 write and read together with room
    host(1, 1, 8'h10, 32'hBEEF0001, 4'hF, 8'h14);
    drain();
    chk(consumed == 9, "R8 both accepted", consumed, 9);

    // R4 one free slot, read held
    ack_en = 1'b0;
    for (int i = 0; i < 3; i++) host(1, 0, 8'(32 + 4*i), 32'hC000 + 32'(i), 4'hF, 8'h0);
    host(1, 1, 8'h3C, 32'hD00D, 4'h1, 8'h20);
    @(negedge clk); #1;
    chk(!s_awready && !s_wready && !s_arready, "R4 stall with held read", {s_awready, s_wready, s_arready}, 0);
    ack_en = 1'b1;
    drain();
    chk(consumed == 14, "R4 held read delivered after write", consumed, 14);
    #1;
    chk(s_awready && s_wready && s_arready, "R4 readies restored", {s_awready, s_wready, s_arready}, 3'b111);

    // R7 erroneous requests
    host(1, 0, 8'h80, 32'h1, 4'hF, 8'h0);
    host(0, 1, 8'h0, 32'h0, 4'h0, 8'h06);
    host(1, 0, 8'h08, 32'h2, 4'h3, 8'h0);
    drain();
    chk(consumed == 17, "R7 errors consumed", consumed, 17);

    // R6 credit gating
    auto_store = 1'b0;
    rsp_free = 3'd0;
    host(1, 0, 8'h00, 32'h51, 4'hF, 8'h0);
    host(1, 0, 8'h04, 32'h52, 4'hF, 8'h0);
    c0 = consumed;
    repeat (4) @(negedge clk);
    chk(consumed == c0 && !rb_en, "R6 no credit", consumed, c0);
    rsp_free = 3'd1;
    repeat (4) @(negedge clk);
    chk(consumed == c0 + 1, "R6 one credit", consumed, c0 + 1);
    man_store = 1'b1;
    repeat (4) @(negedge clk);
    chk(consumed == c0 + 2, "R6 credit returned", consumed, c0 + 2);
    man_store = 1'b1;
    repeat (2) @(negedge clk);
    auto_store = 1'b1;
    rsp_free = 3'd4;

    // R9 chip enable low
    c0 = consumed;
    @(negedge clk);
    ce = 1'b0;
    s_awvalid = 1'b1; s_wvalid = 1'b1; s_arvalid = 1'b1; s_awaddr = 8'h0C; s_araddr = 8'h0C;
    #1;
    chk(!s_awready && !s_wready && !s_arready, "R9 readies low", {s_awready, s_wready, s_arready}, 0);
    repeat (3) @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; s_arvalid = 1'b0;
    ce = 1'b1;
    repeat (4) @(negedge clk);
    chk(consumed == c0, "R9 nothing captured", consumed, c0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule